// File: doc/BRIEF.md
# Receive Word Aligner with Comma Search and Symbol Decode

This block sits after a deserializer that delivers ten raw line bits per clock with no knowledge of where the 10-bit symbols begin. Each cycle it joins the previous and the current raw word into a 20-bit window and looks for a comma at every bit position. A comma is the seven-bit run that opens a symbol, in either polarity. When alignment is enabled, the symbol boundary moves to the lowest offset where a comma was found. When alignment is disabled, the boundary stays where it is. In both cases the comma is still reported.

A comma-detect status output tells the link layer that a comma has been seen since the receiver reached lock. It is forced low while lock is absent. A format input picks what the output carries: either the aligned 10-bit symbol untouched, or a decoded octet with a control flag and a code-violation flag. The decode checks each symbol on its own and does not track running disparity.

Top module: `rx_word_aligner`

## Requirements
- R1: A symbol whose first seven received bits are 0,0,1,1,1,1,1 is a comma, and so is one whose first seven are 1,1,0,0,0,0,0. Received bit order is input bit 0 first, then input bit 9. Either polarity, at any bit offset, sets the comma-detect output.
- R2: While `lock_i` is low, `comma_det_o` is low after the next clock edge, even if commas are present.
- R3: With `lock_i` high, `comma_det_o` rises on the clock edge that samples the raw word completing a comma. It then stays high until `lock_i` goes low. After lock returns, it stays low until another comma is sampled.
- R4: With `align_en_i` high, the symbol boundary moves to the comma. The comma symbol then appears on `data_o` after the second clock edge following the raw word that completes it. This holds at each of the ten bit offsets.
- R5: With `align_en_i` low, the boundary keeps its previous value whatever commas arrive, and `comma_det_o` still reports them.
- R6: With `raw_mode_i` high, `data_o[9:0]` is the aligned symbol with no decoding. `data_o[0]` is the first received bit of the symbol and `data_o[9]` the last.
- R7: With `raw_mode_i` low, a valid data symbol gives `data_o[8]` = 0 and `data_o[7:0]` = the octet. In that octet, bits 7..5 come from the 4-bit sub-block and bits 4..0 from the 6-bit sub-block.
- R8: With `raw_mode_i` low, the control symbols K28.0 to K28.7, in either polarity, give `data_o[8]` = 1 and `data_o[7:0]` = 0x1C + 32*y.
- R9: With `raw_mode_i` low, a symbol that is neither a valid data symbol nor a K28.y symbol gives `data_o[9]` = 1 and `data_o[8:0]` = 0 for that one output cycle only. The next valid symbol clears `data_o[9]`.
- R10: Synchronous reset clears `data_o` and `comma_det_o`. It also sets the boundary to word alignment, so a symbol that fills one whole raw word passes through unshifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_word_i | input | 10 | Raw deserialized bits, bit 0 received first |
| lock_i | input | 1 | Receiver lock indication, high when locked |
| align_en_i | input | 1 | High lets commas move the symbol boundary |
| raw_mode_i | input | 1 | High: raw 10-bit symbol out; low: decoded format |
| data_o | output | 10 | Aligned symbol, or {violation, control, octet} |
| comma_det_o | output | 1 | Comma seen since lock, gated by lock |

## Verification
The bench places a comma at each of the ten bit offsets and alternates the two polarities. An aligner that tests only nine window positions, or that slices the window off by one bit, returns a shifted symbol at one offset. A comma is also fed with alignment disabled: a design that still realigns returns the comma there instead of the expected fragment from the old boundary. Lock is dropped while commas are present and again after detection, which catches a status flag that is not gated or is not cleared. A vector walk through data, K28 and invalid symbols catches decoders that misread complemented sub-blocks or leave the violation flag high for more than one cycle.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

    localparam int CW = 10;

    localparam logic [6:0] COMMA_A = 7'b0011111;
    localparam logic [6:0] COMMA_B = 7'b1100000;

    typedef struct packed {
        logic       viol;
        logic       ctrl;
        logic [7:0] octet;
    } dec_t;

    // first seven received bits, first bit at the left
    function automatic logic [6:0] lead7(input logic [CW-1:0] s);
        return {s[0], s[1], s[2], s[3], s[4], s[5], s[6]};
    endfunction

    function automatic logic is_comma(input logic [CW-1:0] s);
        return (lead7(s) == COMMA_A) || (lead7(s) == COMMA_B);
    endfunction

    // 6-bit sub-block, first bit at the left, negative-disparity form
    function automatic logic [5:0] code6(input logic [4:0] v);
        case (v)
            5'd0:  return 6'b100111;  5'd1:  return 6'b011101;
            5'd2:  return 6'b101101;  5'd3:  return 6'b110001;
            5'd4:  return 6'b110101;  5'd5:  return 6'b101001;
            5'd6:  return 6'b011001;  5'd7:  return 6'b111000;
            5'd8:  return 6'b111001;  5'd9:  return 6'b100101;
            5'd10: return 6'b010101;  5'd11: return 6'b110100;
            5'd12: return 6'b001101;  5'd13: return 6'b101100;
            5'd14: return 6'b011100;  5'd15: return 6'b010111;
            5'd16: return 6'b011011;  5'd17: return 6'b100011;
            5'd18: return 6'b010011;  5'd19: return 6'b110010;
            5'd20: return 6'b001011;  5'd21: return 6'b101010;
            5'd22: return 6'b011010;  5'd23: return 6'b111010;
            5'd24: return 6'b110011;  5'd25: return 6'b100110;
            5'd26: return 6'b010110;  5'd27: return 6'b110110;
            5'd28: return 6'b001110;  5'd29: return 6'b101110;
            5'd30: return 6'b011110;  default: return 6'b101011;
        endcase
    endfunction

    // 4-bit sub-block of data symbols, primary form
    function automatic logic [3:0] code4(input logic [2:0] v);
        case (v)
            3'd0: return 4'b1011;  3'd1: return 4'b1001;
            3'd2: return 4'b0101;  3'd3: return 4'b1100;
            3'd4: return 4'b1101;  3'd5: return 4'b1010;
            3'd6: return 4'b0110;  default: return 4'b1110;
        endcase
    endfunction

    // 4-bit sub-block following the 001111 control prefix
    function automatic logic [3:0] kcode4(input logic [2:0] v);
        case (v)
            3'd0: return 4'b0100;  3'd1: return 4'b1001;
            3'd2: return 4'b0101;  3'd3: return 4'b0011;
            3'd4: return 4'b0010;  3'd5: return 4'b1010;
            3'd6: return 4'b0110;  default: return 4'b1000;
        endcase
    endfunction

    function automatic dec_t decode(input logic [CW-1:0] s);
        logic [5:0] g6;
        logic [3:0] g4;
        logic [3:0] kc;
        logic [5:0] c6;
        logic [3:0] c4;
        logic       ok5;
        logic       ok3;
        logic       bal;
        logic [4:0] v5;
        logic [2:0] v3;
        dec_t       r;
        g6  = {s[0], s[1], s[2], s[3], s[4], s[5]};
        g4  = {s[6], s[7], s[8], s[9]};
        r   = '{viol: 1'b1, ctrl: 1'b0, octet: 8'h00};
        ok5 = 1'b0;
        ok3 = 1'b0;
        v5  = '0;
        v3  = '0;
        if (g6 == 6'b001111 || g6 == 6'b110000) begin
            for (int y = 0; y < 8; y++) begin
                kc = (g6 == 6'b001111) ? kcode4(3'(y)) : ~kcode4(3'(y));
                if (g4 == kc) begin
                    ok3 = 1'b1;
                    v3  = 3'(y);
                end
            end
            if (ok3) r = '{viol: 1'b0, ctrl: 1'b1, octet: {v3, 5'd28}};
        end else begin
            for (int i = 0; i < 32; i++) begin
                c6  = code6(5'(i));
                bal = ($countones(c6) == 3) && (i != 7);
                if (g6 == c6 || (!bal && g6 == ~c6)) begin
                    ok5 = 1'b1;
                    v5  = 5'(i);
                end
            end
            for (int j = 0; j < 8; j++) begin
                c4  = code4(3'(j));
                bal = ($countones(c4) == 2) && (j != 3);
                if (g4 == c4 || (!bal && g4 == ~c4) ||
                    (j == 7 && (g4 == 4'b0111 || g4 == 4'b1000))) begin
                    ok3 = 1'b1;
                    v3  = 3'(j);
                end
            end
            if (ok5 && ok3) r = '{viol: 1'b0, ctrl: 1'b0, octet: {v3, v5}};
        end
        return r;
    endfunction

endpackage

// File: rtl/rxa_comma_scan.sv
module rxa_comma_scan #(
    parameter  int SYM_W = rxa_pkg::CW,
    localparam int OFF_W = $clog2(SYM_W + 1)
) (
    input  logic [SYM_W-1:0] cur_i,
    input  logic [SYM_W-1:0] prev_i,
    output logic             hit_any_o,
    output logic [OFF_W-1:0] hit_off_o
);
    logic [2*SYM_W-1:0] win;
    logic [SYM_W:1]     hit;

    assign win = {cur_i, prev_i};

    // offset k: symbol occupies window bits k .. k+SYM_W-1
    for (genvar k = 1; k <= SYM_W; k++) begin : g_pos
        assign hit[k] = rxa_pkg::is_comma(win[k +: SYM_W]);
    end

    // lowest offset wins
    always_comb begin
        hit_any_o = 1'b0;
        hit_off_o = OFF_W'(SYM_W);
        for (int k = SYM_W; k >= 1; k--) begin
            if (hit[k]) begin
                hit_any_o = 1'b1;
                hit_off_o = OFF_W'(k);
            end
        end
    end
endmodule

// File: rtl/rxa_boundary.sv
module rxa_boundary #(
    parameter  int SYM_W = rxa_pkg::CW,
    localparam int OFF_W = $clog2(SYM_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SYM_W-1:0] cur_i,
    input  logic             align_en_i,
    input  logic             hit_any_i,
    input  logic [OFF_W-1:0] hit_off_i,
    output logic [SYM_W-1:0] prev_o,
    output logic [SYM_W-1:0] sym_o
);
    logic [SYM_W-1:0]   prev_q;
    logic [OFF_W-1:0]   off_q;
    logic [OFF_W-1:0]   off_nxt;
    logic [SYM_W-1:0]   sym_q;
    logic [2*SYM_W-1:0] win;

    assign win     = {cur_i, prev_q};
    assign off_nxt = (align_en_i && hit_any_i) ? hit_off_i : off_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            off_q  <= OFF_W'(SYM_W);
            sym_q  <= '0;
        end else begin
            prev_q <= cur_i;
            off_q  <= off_nxt;
            sym_q  <= win[off_nxt +: SYM_W];
        end
    end

    assign prev_o = prev_q;
    assign sym_o  = sym_q;

    p_offset_range_r4: assert property (@(posedge clk) disable iff (rst)
        (off_q >= OFF_W'(1)) && (off_q <= OFF_W'(SYM_W)));

    p_offset_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        !align_en_i |=> $stable(off_q));
endmodule

// File: rtl/rxa_status.sv
module rxa_status (
    input  logic clk,
    input  logic rst,
    input  logic lock_i,
    input  logic hit_any_i,
    output logic comma_det_o
);
    logic det_q;

    always_ff @(posedge clk) begin
        if (rst)            det_q <= 1'b0;
        else if (!lock_i)   det_q <= 1'b0;
        else if (hit_any_i) det_q <= 1'b1;
    end

    assign comma_det_o = det_q;

    p_cdet_unlocked_r2: assert property (@(posedge clk) disable iff (rst)
        !lock_i |=> !det_q);

    p_cdet_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(det_q) |-> $past(lock_i) && $past(hit_any_i));

    p_cdet_hold_r3: assert property (@(posedge clk) disable iff (rst)
        det_q && lock_i |=> det_q);
endmodule

// File: rtl/rxa_format.sv
module rxa_format #(
    parameter int SYM_W = rxa_pkg::CW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_mode_i,
    input  logic [SYM_W-1:0] sym_i,
    output logic [SYM_W-1:0] data_o
);
    rxa_pkg::dec_t    dec;
    logic [SYM_W-1:0] out_q;

    assign dec = rxa_pkg::decode(sym_i);

    always_ff @(posedge clk) begin
        if (rst)             out_q <= '0;
        else if (raw_mode_i) out_q <= sym_i;
        else                 out_q <= SYM_W'(dec);
    end

    assign data_o = out_q;

    p_viol_clean_r9: assert property (@(posedge clk) disable iff (rst)
        $past(!raw_mode_i) && out_q[SYM_W-1] |-> (out_q[SYM_W-2:0] == '0));
endmodule

// File: rtl/rx_word_aligner.sv
module rx_word_aligner #(
    parameter  int SYM_W = rxa_pkg::CW,
    localparam int OFF_W = $clog2(SYM_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SYM_W-1:0] rx_word_i,
    input  logic             lock_i,
    input  logic             align_en_i,
    input  logic             raw_mode_i,
    output logic [SYM_W-1:0] data_o,
    output logic             comma_det_o
);
    logic [SYM_W-1:0] prev;
    logic [SYM_W-1:0] sym;
    logic             hit_any;
    logic [OFF_W-1:0] hit_off;

    rxa_comma_scan #(.SYM_W(SYM_W)) u_scan (
        .cur_i     (rx_word_i),
        .prev_i    (prev),
        .hit_any_o (hit_any),
        .hit_off_o (hit_off)
    );

    rxa_boundary #(.SYM_W(SYM_W)) u_bound (
        .clk        (clk),
        .rst        (rst),
        .cur_i      (rx_word_i),
        .align_en_i (align_en_i),
        .hit_any_i  (hit_any),
        .hit_off_i  (hit_off),
        .prev_o     (prev),
        .sym_o      (sym)
    );

    rxa_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .lock_i      (lock_i),
        .hit_any_i   (hit_any),
        .comma_det_o (comma_det_o)
    );

    rxa_format #(.SYM_W(SYM_W)) u_fmt (
        .clk        (clk),
        .rst        (rst),
        .raw_mode_i (raw_mode_i),
        .sym_i      (sym),
        .data_o     (data_o)
    );
endmodule

// File: tb/tb_rx_word_aligner.sv
module tb_rx_word_aligner;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] rx_word = '0;
    logic       lock = 1'b0;
    logic       align_en = 1'b0;
    logic       raw_mode = 1'b1;
    logic [9:0] data;
    logic       cdet;

    int total = 0;
    int bad   = 0;

    // codes stored with bit 0 = first received bit
    localparam logic [9:0] KM = 10'b0101111100; // K28.5, 0011111010 on the line
    localparam logic [9:0] KP = 10'b1010000011; // K28.5, 1100000101 on the line

    // {symbol, expected decoded output}
    localparam int NV = 12;
    localparam logic [19:0] VEC [NV] = '{
        {10'b0101111100, 10'h1BC}, // K28.5 negative  R8
        {10'b1010000011, 10'h1BC}, // K28.5 positive  R8
        {10'b0101010101, 10'h0B5}, // D21.5           R7
        {10'b1010110110, 10'h050}, // D16.2           R7
        {10'b0010111001, 10'h000}, // D0.0            R7
        {10'b0011100011, 10'h063}, // D3.3            R7
        {10'b0010111100, 10'h11C}, // K28.0           R8
        {10'b1110000011, 10'h1FC}, // K28.7 positive  R8
        {10'b0000000000, 10'h200}, // invalid         R9
        {10'b0111000111, 10'h0E7}, // D7.7            R9 clear
        {10'b1111010101, 10'h200}, // bad 4-bit part  R9
        {10'b1001010111, 10'h037}  // D23.1           R9 clear
    };

    rx_word_aligner dut (
        .clk         (clk),
        .rst         (rst),
        .rx_word_i   (rx_word),
        .lock_i      (lock),
        .align_en_i  (align_en),
        .raw_mode_i  (raw_mode),
        .data_o      (data),
        .comma_det_o (cdet)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [9:0] w);
        @(negedge clk);
        rx_word = w;
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog act=%h exp=%h", 10'h0, 10'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [49:0] buf50;
        int          c;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 reset data", data, 10'h000);
        check("R10 reset cdet", {9'd0, cdet}, 10'h000);

        // R10: word-aligned boundary after reset, alignment off
        lock = 1'b1;
        step(KM);
        step(10'h000);
        @(negedge clk);
        check("R10 reset boundary", data, KM);

        // R1 R3 R4 R6: comma at each bit offset, both polarities
        align_en = 1'b1;
        for (int s = 0; s < 10; s++) begin
            buf50 = 50'((s % 2 == 1) ? KP : KM) << (10 + s);
            c = (s == 0) ? 1 : 2;
            @(negedge clk);
            lock    = 1'b0;
            rx_word = '0;
            for (int j = 0; j < 5; j++) begin
                @(negedge clk);
                if (j == c)     check("R3 cdet before comma", {9'd0, cdet}, 10'h000);
                if (j == c + 1) check("R1 cdet after comma", {9'd0, cdet}, 10'h001);
                if (j == c + 2) check("R4 aligned symbol", data, (s % 2 == 1) ? KP : KM);
                lock    = 1'b1;
                rx_word = buf50[10*j +: 10];
            end
        end

        // R5: alignment off, boundary stays at offset 9, comma still reported
        align_en = 1'b0;
        buf50 = 50'(KM) << 14;
        @(negedge clk);
        lock    = 1'b0;
        rx_word = '0;
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            if (j == 3) check("R5 cdet still reported", {9'd0, cdet}, 10'h001);
            if (j == 4) check("R5 boundary unchanged", data, buf50[19 +: 10]);
            lock    = 1'b1;
            rx_word = buf50[10*j +: 10];
        end

        // R2: commas while unlocked
        align_en = 1'b1;
        buf50 = 50'(KM) << 12;
        @(negedge clk);
        lock = 1'b0;
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            if (j >= 2) check("R2 cdet gated by lock", {9'd0, cdet}, 10'h000);
            rx_word = buf50[10*j +: 10];
        end

        // R3: hold while locked, clear on loss, stay low after relock
        lock = 1'b1;
        for (int j = 0; j < 5; j++) step(buf50[10*j +: 10]);
        repeat (3) step(10'h000);
        @(negedge clk);
        check("R3 cdet holds", {9'd0, cdet}, 10'h001);
        lock = 1'b0;
        @(negedge clk);
        check("R3 cdet clears on lock loss", {9'd0, cdet}, 10'h000);
        lock = 1'b1;
        step(10'h000);
        step(10'h000);
        @(negedge clk);
        check("R3 cdet low after relock", {9'd0, cdet}, 10'h000);

        // R7 R8 R9: decoded format, word-aligned stream
        raw_mode = 1'b0;
        align_en = 1'b1;
        step(KM);
        step(10'h000);
        @(negedge clk);
        align_en = 1'b0;
        for (int j = 0; j < NV + 2; j++) begin
            @(negedge clk);
            if (j >= 2) check("R7/R8/R9 decode vector", data, VEC[j-2][9:0]);
            rx_word = (j < NV) ? VEC[j][19:10] : 10'h000;
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule